// File: doc/BRIEF.md
# Conditional Integer ALU with Condition Flags

This block carries out one integer data-processing operation per clock and works out the next value of the four condition flags: negative (N), zero (Z), carry (C) and overflow (V). An instruction decoder supplies a 4-bit operation code, a set-flags bit, a 4-bit condition code, the first operand, the second operand that a barrel shifter has already prepared, and that shifter's carry-out. The register file supplies the current flags. Each cycle the block first evaluates the condition code against the incoming flags. Only when the condition passes does the operation update the flags or ask for a destination write.

Logical operations take their carry from the shifter and leave V alone. Add and subtract forms compute a true carry or not-borrow and a signed overflow. The four test and compare operations produce flags only. All outputs are registered, so results appear one clock after the inputs are presented. The write enable and next-flags outputs feed the register file and the flags register, which lie outside this block.

Top module: `cdp_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `result_o` = 0, `wr_en_o` = 0 and `flags_o` = 0.
- R2: Flags are packed as {N,Z,C,V} in bits 3..0. The conditions are: 0 Z set; 1 Z clear; 2 C set; 3 C clear; 4 N set; 5 N clear; 6 V set; 7 V clear; 8 C set and Z clear; 9 C clear or Z set; 10 N equals V; 11 N differs from V; 12 Z clear and N equals V; 13 Z set or N differs from V; 14 always passes; 15 never passes.
- R3: When the condition fails, the next `wr_en_o` is 0 and the next `flags_o` equals the incoming flags.
- R4: When `set_flags_i` is 0, the next `flags_o` equals the incoming flags. When it is 1 and the condition passes, the flags are updated by the rules in R5 to R8, with N taken from result bit W-1 and Z set when the result is zero.
- R5: The logical opcodes are 0 AND, 1 XOR, 8 test-AND, 9 test-XOR, 12 OR, 13 move, 14 first AND NOT second, and 15 NOT second. Each of them loads C from the shifter carry-out and keeps V.
- R6: Opcodes 2 (first minus second), 3 (second minus first) and 10 (compare, first minus second) set C when no borrow occurs, meaning the subtrahend is not larger than the minuend, unsigned. They set V when the signed difference falls outside the W-bit range.
- R7: Opcodes 4 (add) and 11 (compare-negative, add) set C when the unsigned sum exceeds 2^W-1. They set V when the signed sum falls outside the W-bit range.
- R8: Opcode 5 adds the incoming C. Opcodes 6 (first minus second) and 7 (second minus first) subtract an extra one when the incoming C is clear. All three follow the carry and overflow rules of R6 and R7 on the full computation.
- R9: Opcodes 8 to 11 never assert `wr_en_o`. Every other opcode asserts it exactly when the condition passes.
- R10: `result_o`, `wr_en_o` and `flags_o` reflect the inputs sampled at the previous rising edge and hold between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_i | input | 4 | Condition code |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Flag update request |
| rn_i | input | DATA_W | First operand |
| shop_i | input | DATA_W | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | DATA_W | Registered operation result |
| wr_en_o | output | 1 | Destination write request |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with DATA_W = 8 rather than the default 32. At that width, random operands hit unsigned wrap, signed overflow, zero results and borrow-versus-equal boundaries often, and a directed list pins each of these down. All sixteen condition codes are exercised against random flag values, so both pass and fail paths of every predicate are covered. The carry-in opcodes are driven with both values of the incoming C.

// File: rtl/cdp_alu_pkg.sv
// Package: shared encodings for the conditional ALU.
// Assumes flags are packed {N,Z,C,V} in bits 3..0.
package cdp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // True for operations whose carry comes from the shifter.
    function automatic logic op_is_logical(input alu_op_e op);
        return op inside {OP_AND, OP_EOR, OP_TST, OP_TEQ,
                          OP_ORR, OP_MOV, OP_BIC, OP_MVN};
    endfunction

    // True for operations that only produce flags.
    function automatic logic op_is_test(input alu_op_e op);
        return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
    endfunction

endpackage

// File: rtl/cdp_cond_eval.sv
// Condition evaluator: decides whether an operation executes,
// given the 4-bit condition code and the current {N,Z,C,V} flags.
// Assumes: purely combinational; code 15 is treated as never.
module cdp_cond_eval
    import cdp_alu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);

    logic n, z, c, v;
    assign n = flags_i[FLAG_N];
    assign z = flags_i[FLAG_Z];
    assign c = flags_i[FLAG_C];
    assign v = flags_i[FLAG_V];

    // Predicate select per condition code.
    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ:   pass_o = z;
            CC_NE:   pass_o = !z;
            CC_CS:   pass_o = c;
            CC_CC:   pass_o = !c;
            CC_MI:   pass_o = n;
            CC_PL:   pass_o = !n;
            CC_VS:   pass_o = v;
            CC_VC:   pass_o = !v;
            CC_HI:   pass_o = c && !z;
            CC_LS:   pass_o = !c || z;
            CC_GE:   pass_o = (n == v);
            CC_LT:   pass_o = (n != v);
            CC_GT:   pass_o = !z && (n == v);
            CC_LE:   pass_o = z || (n != v);
            CC_AL:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cdp_logic_unit.sv
// Bitwise unit: computes the logical operation results.
// Assumes the caller ignores the output for arithmetic opcodes.
module cdp_logic_unit
    import cdp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);

    // Bitwise function per logical opcode.
    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/cdp_arith_unit.sv
// Arithmetic unit: one shared adder serves every add and subtract form.
// Subtraction is done as x + ~y + carry_in, so the carry-out is the
// not-borrow. Assumes the caller ignores the outputs for logical opcodes.
module cdp_arith_unit
    import cdp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] sh_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              ovf_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x, y;
    logic              ci;
    logic [DATA_W:0]   sum;

    // Operand steering and carry-in selection per opcode.
    always_comb begin
        x  = rn_i;
        y  = sh_i;
        ci = 1'b0;
        unique case (op_i)
            OP_SUB, OP_CMP: begin y = ~sh_i; ci = 1'b1;  end
            OP_RSB:         begin x = sh_i; y = ~rn_i; ci = 1'b1; end
            OP_ADC:         begin ci = cin_i; end
            OP_SBC:         begin y = ~sh_i; ci = cin_i; end
            OP_RSC:         begin x = sh_i; y = ~rn_i; ci = cin_i; end
            default:        begin ci = 1'b0; end
        endcase
    end

    // Shared adder with carry and signed overflow.
    always_comb begin
        sum     = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
        res_o   = sum[MSB:0];
        carry_o = sum[DATA_W];
        ovf_o   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/cdp_alu.sv
// Conditional ALU top: gates one operation with the condition code,
// picks the logical or arithmetic result, forms the next flags and
// registers all outputs. Assumes operand two is already shifted and
// that flag and register storage live outside.
module cdp_alu
    import cdp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        opcode_i,
    input  logic              set_flags_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] shop_i,
    input  logic              shc_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);

    localparam int MSB = DATA_W - 1;

    alu_op_e           op;
    logic              cond_pass;
    logic [DATA_W-1:0] logic_res, arith_res, res;
    logic              arith_c, arith_v;
    logic              is_logic, is_test;
    logic [3:0]        new_flags, next_flags;

    assign op       = alu_op_e'(opcode_i);
    assign is_logic = op_is_logical(op);
    assign is_test  = op_is_test(op);

    cdp_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_i),
        .pass_o  (cond_pass)
    );

    cdp_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op_i  (op),
        .a_i   (rn_i),
        .b_i   (shop_i),
        .res_o (logic_res)
    );

    cdp_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op_i    (op),
        .rn_i    (rn_i),
        .sh_i    (shop_i),
        .cin_i   (flags_i[FLAG_C]),
        .res_o   (arith_res),
        .carry_o (arith_c),
        .ovf_o   (arith_v)
    );

    // Result selection and next-flag formation.
    always_comb begin
        res = is_logic ? logic_res : arith_res;
        new_flags[FLAG_N] = res[MSB];
        new_flags[FLAG_Z] = (res == '0);
        new_flags[FLAG_C] = is_logic ? shc_i : arith_c;
        new_flags[FLAG_V] = is_logic ? flags_i[FLAG_V] : arith_v;
        next_flags = (cond_pass && set_flags_i) ? new_flags : flags_i;
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_o  <= 4'h0;
        end else begin
            result_o <= res;
            wr_en_o  <= cond_pass && !is_test;
            flags_o  <= next_flags;
        end
    end

    p_fail_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |=> (!wr_en_o && flags_o == $past(flags_i)));

    p_noset_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> (flags_o == $past(flags_i)));

    p_logic_vkeep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> (flags_o[FLAG_V] == $past(flags_i[FLAG_V])));

    p_test_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i inside {4'd8, 4'd9, 4'd10, 4'd11}) |=> !wr_en_o);

    p_always_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'd14 && !is_test) |=> wr_en_o);

    p_never_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'd15) |=> (!wr_en_o && $stable(flags_o) == (flags_o == $past(flags_i)) || flags_o == $past(flags_i)));

endmodule

// File: tb/tb_cdp_alu.sv
`timescale 1ns/1ps
module tb_cdp_alu;

    localparam int W = 8;
    localparam longint FULL = longint'(1) << W;
    localparam longint HALF = longint'(1) << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   cond_i, opcode_i, flags_i;
    logic         set_flags_i, shc_i;
    logic [W-1:0] rn_i, shop_i;
    logic [W-1:0] result_o;
    logic         wr_en_o;
    logic [3:0]   flags_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;   // 250 MHz

    cdp_alu #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .opcode_i(opcode_i),
        .set_flags_i(set_flags_i), .rn_i(rn_i), .shop_i(shop_i),
        .shc_i(shc_i), .flags_i(flags_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Condition predicate per R2.
    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic longint sgn(input logic [W-1:0] x);
        longint u = longint'(x);
        return (u >= HALF) ? u - FULL : u;
    endfunction

    function automatic logic oor(input longint s);
        return (s < -HALF) || (s > HALF - 1);
    endfunction

    // Reference model per R3 to R9.
    function automatic void model(input logic [3:0] c, op, input logic s,
                                  input logic [W-1:0] rn, sh, input logic shc,
                                  input logic [3:0] f, output logic [W-1:0] r,
                                  output logic wr, output logic [3:0] fo);
        longint ur = longint'(rn), us = longint'(sh);
        longint sr = sgn(rn), ss = sgn(sh);
        longint ci = longint'(f[1]);
        longint bi = 1 - ci;
        logic lg = 1'b0, cy = 1'b0, v = 1'b0;
        logic pass = cond_ok(c, f);
        case (op)
            4'd0, 4'd8:  begin r = rn & sh; lg = 1; end
            4'd1, 4'd9:  begin r = rn ^ sh; lg = 1; end
            4'd12:       begin r = rn | sh; lg = 1; end
            4'd13:       begin r = sh; lg = 1; end
            4'd14:       begin r = rn & ~sh; lg = 1; end
            4'd15:       begin r = ~sh; lg = 1; end
            4'd2, 4'd10: begin r = W'(ur - us); cy = ur >= us; v = oor(sr - ss); end
            4'd3:        begin r = W'(us - ur); cy = us >= ur; v = oor(ss - sr); end
            4'd4, 4'd11: begin r = W'(ur + us); cy = (ur + us) >= FULL; v = oor(sr + ss); end
            4'd5:        begin r = W'(ur + us + ci); cy = (ur + us + ci) >= FULL; v = oor(sr + ss + ci); end
            4'd6:        begin r = W'(ur - us - bi); cy = ur >= us + bi; v = oor(sr - ss - bi); end
            default:     begin r = W'(us - ur - bi); cy = us >= ur + bi; v = oor(ss - sr - bi); end
        endcase
        wr = pass && !(op inside {4'd8, 4'd9, 4'd10, 4'd11});
        fo = f;
        if (pass && s)
            fo = lg ? {r[W-1], r == '0, shc, f[0]} : {r[W-1], r == '0, cy, v};
    endfunction

    function automatic string res_tag(input logic [3:0] op);
        if (op inside {4'd5, 4'd6, 4'd7}) return "R8 result";
        if (op inside {4'd2, 4'd3, 4'd10}) return "R6 result";
        if (op inside {4'd4, 4'd11}) return "R7 result";
        return "R5 result";
    endfunction

    // Drive at a falling edge, sample at the next falling edge (R10: one register).
    task automatic run_op(input logic [3:0] c, op, input logic s,
                          input logic [W-1:0] rn, sh, input logic shc,
                          input logic [3:0] f);
        logic [W-1:0] er;
        logic ew;
        logic [3:0] ef;
        cond_i = c; opcode_i = op; set_flags_i = s;
        rn_i = rn; shop_i = sh; shc_i = shc; flags_i = f;
        model(c, op, s, rn, sh, shc, f, er, ew, ef);
        @(negedge clk);
        check(res_tag(op), result_o, er);
        check((op inside {4'd8, 4'd9, 4'd10, 4'd11}) ? "R9 wr_en" : "R3 wr_en", wr_en_o, ew);
        check(s ? "R4 flags" : "R4 flags held", flags_o, ef);
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom % 6)
            0: return '0;
            1: return W'(HALF - 1);
            2: return W'(HALF);
            3: return '1;
            default: return W'($urandom);
        endcase
    endfunction

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog R10 actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        rst_n = 1'b0;
        cond_i = 4'd14; opcode_i = 4'd13; set_flags_i = 1'b1;
        rn_i = '1; shop_i = '1; shc_i = 1'b1; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 result", result_o, 0);
        check("R1 wr_en", wr_en_o, 0);
        check("R1 flags", flags_o, 0);
        rst_n = 1'b1;

        // R10: output holds until the edge
        cond_i = 4'd14; opcode_i = 4'd13; set_flags_i = 1'b0;
        shop_i = 8'h5C; flags_i = 4'h0;
        #1 check("R10 before edge", result_o, 0);
        @(negedge clk);
        check("R10 after edge", result_o, 8'h5C);

        // Directed corners
        run_op(4'd14, 4'd13, 1, 8'h00, 8'h00, 1, 4'h1);   // R5 zero, C from shifter, V kept
        run_op(4'd14, 4'd15, 1, 8'h00, 8'h00, 0, 4'h2);   // R5 NOT -> negative
        run_op(4'd14, 4'd14, 1, 8'hF0, 8'h30, 0, 4'h0);   // R5 AND NOT
        run_op(4'd14, 4'd2,  1, 8'h40, 8'h40, 0, 4'h0);   // R6 equal: C=1 Z=1
        run_op(4'd14, 4'd2,  1, 8'h00, 8'h01, 0, 4'h0);   // R6 borrow: C=0
        run_op(4'd14, 4'd10, 1, 8'h80, 8'h01, 0, 4'h0);   // R6 signed overflow
        run_op(4'd14, 4'd3,  1, 8'h05, 8'h03, 0, 4'h0);   // R6 reverse
        run_op(4'd14, 4'd4,  1, 8'h7F, 8'h01, 0, 4'h0);   // R7 overflow
        run_op(4'd14, 4'd11, 1, 8'hFF, 8'h01, 0, 4'h0);   // R7 wrap carry
        run_op(4'd14, 4'd5,  1, 8'hFF, 8'h00, 0, 4'h2);   // R8 carry-in wraps
        run_op(4'd14, 4'd6,  1, 8'h05, 8'h05, 0, 4'h0);   // R8 extra borrow
        run_op(4'd14, 4'd7,  1, 8'h05, 8'h05, 0, 4'h2);   // R8 no extra borrow
        run_op(4'd15, 4'd4,  1, 8'h01, 8'h01, 0, 4'hA);   // R2 never
        run_op(4'd0,  4'd4,  1, 8'h01, 8'h01, 0, 4'h0);   // R3 fail on Z clear
        run_op(4'd14, 4'd4,  0, 8'hFF, 8'h01, 0, 4'h5);   // R4 no update
        run_op(4'd14, 4'd8,  1, 8'hFF, 8'hFF, 1, 4'h0);   // R9 test

        // Condition sweep: R2
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                run_op(4'(c), 4'd13, 1, 8'h11, 8'h22, 1, 4'(f));

        // Random mix
        for (int i = 0; i < 600; i++)
            run_op(4'($urandom), 4'($urandom), 1'($urandom), pick(), pick(),
                   1'($urandom), 4'($urandom));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule